// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous request port and an external 16-bit asynchronous static RAM with 19 address bits. It handles one word per request. A request carries an address, write data, a write flag and one enable per byte lane. The controller accepts it with a valid/ready handshake. It then plays out the strobe sequence the memory needs and, for a read, returns the word with a single-cycle valid pulse.

Every phase of that sequence is counted in system clocks. The clock counts come from timing parameters given in picoseconds. Each count is rounded up to whole clocks and never falls below one clock. The memory's address changes only while every strobe is inactive. Output enable is raised before any write begins. After a read, the controller waits out the memory's bus release time before it can accept another request.

The data bus is split into an output word, an input word and a drive-enable. A pad ring or the enclosing level joins these into the bidirectional pins.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, chip enable, write enable, output enable and every byte select are high (inactive), the bus drive-enable is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `mem_addr` takes a new value only at a clock edge where all strobes are high both before and after that edge.
- R3: For a write, the accepting edge starts the sequence. First come N_AS cycles with all strobes high. Next come N_WP cycles with chip enable and write enable low and output enable high. Last come N_WH cycles with all strobes high, after which `req_ready` returns. Here N_AS = ceil(T_ADDR_SETUP_PS/CLK_PERIOD_PS), and N_WH is the same rounding of the write hold time. N_WP = max(ceil(pulse), ceil(data setup), ceil(write cycle) − N_AS − N_WH). Every count is at least 1.
- R4: Byte select bit 0 (`mem_bsel_n[0]`) gates data bits 7:0 and bit 1 gates bits 15:8. In the active phase, a select is low exactly when its bit in `req_be` was 1 at acceptance. Outside the active phase, every select is high.
- R5: `mem_dq_oe` is 1 only during the write pulse and write hold phases. While it is 1, `mem_dq_out` carries the accepted write data and output enable is high.
- R6: Output enable and write enable are never low in the same cycle.
- R7: For a read, N_AS cycles with all strobes high are followed by N_RD cycles with chip enable and output enable low and write enable high. N_RD = max(ceil(address access), ceil(output-enable access), ceil(read cycle) − N_AS), and is at least 1.
- R8: Read data is sampled in the last read-phase cycle. Lanes whose enable was 0 return zero. `rsp_valid` is 1 for exactly the one cycle that follows that sample.
- R9: After a read, N_REL = ceil(T_OE_RELEASE_PS/CLK_PERIOD_PS) cycles with all strobes high pass before `req_ready` returns.
- R10: `req_ready` is 1 only when the controller is idle. A request presented while the controller is busy has no effect on the memory.
- R11: A request with both byte enables 0 toggles no strobe and leaves `mem_addr` unchanged. `req_ready` stays 1. For a read, `rsp_valid` pulses in the next cycle with `rsp_rdata` equal to 0.
- R12: A written word reads back with only its enabled lanes changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this edge if valid |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bsel_n | output | 2 | Byte selects, active low, bit 0 = lower lane |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The bench runs the controller with timing parameters that make every phase more than one clock, where it can. The write pulse is padded by the cycle-time rule. It measures each phase length against the rounded-up counts, so a design that skipped the padding or rounded down would show a short phase. The bench sweeps all four byte-enable patterns over low, high and mixed addresses. A swapped or ignored lane would show up as a wrong readback. Two further checks cover control behaviour. A request held during a busy transaction targets an address that the bench never writes, so a design that accepts while busy leaves a visible write there. A per-cycle monitor catches address changes under an active strobe, the bus driven while output enable is low, and output enable overlapping a write.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared phase encoding and the clock-count conversion.
// Assumes all timing values are non-negative picosecond integers.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WPULSE,
        PH_WHOLD,
        PH_READ,
        PH_TURN
    } phase_e;

    // Whole clocks covering t_ps, never fewer than one.
    function automatic int clocks_for(input int t_ps, input int period_ps);
        int n;
        n = (t_ps + period_ps - 1) / period_ps;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Module: down-counter that measures one phase.
// Loading LEN makes 'last' rise LEN-1 cycles later; LEN is at least 1.
module sram_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on a phase start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_capture.sv
// Module: per-lane read data register with masking.
// Assumes 'capture' and 'clear' are never high together.
module sram_lane_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              clear,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Hold, load masked byte, or zero this lane.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                rdata[g*8 +: 8] <= '0;
            else if (capture)
                rdata[g*8 +: 8] <= lane_en[g] ? dq_in[g*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
// Module: request-to-pin sequencer for an asynchronous static RAM.
// Each request walks through address setup, an active phase (write pulse
// or read), then a trailing phase with all strobes high (write hold or bus
// release). Phase lengths are rounded up from picosecond parameters.
// Assumes mem_dq_in is stable by the last read-phase clock.
module sram_async_ctrl #(
    parameter int ADDR_W            = 19,
    parameter int DATA_W            = 16,
    parameter int CNT_W             = 8,
    parameter int CLK_PERIOD_PS     = 20000,
    parameter int T_ADDR_SETUP_PS   = 0,
    parameter int T_WE_PULSE_PS     = 8000,
    parameter int T_DATA_SETUP_PS   = 6000,
    parameter int T_WR_HOLD_PS      = 0,
    parameter int T_WR_CYCLE_PS     = 10000,
    parameter int T_ADDR_ACCESS_PS  = 10000,
    parameter int T_OE_ACCESS_PS    = 4500,
    parameter int T_RD_CYCLE_PS     = 10000,
    parameter int T_OE_RELEASE_PS   = 4000,
    localparam int LANES            = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_bsel_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    import sram_ctrl_pkg::*;

    localparam int N_AS  = clocks_for(T_ADDR_SETUP_PS, CLK_PERIOD_PS);
    localparam int N_WH  = clocks_for(T_WR_HOLD_PS, CLK_PERIOD_PS);
    localparam int N_WP  = max3(clocks_for(T_WE_PULSE_PS, CLK_PERIOD_PS),
                                clocks_for(T_DATA_SETUP_PS, CLK_PERIOD_PS),
                                clocks_for(T_WR_CYCLE_PS, CLK_PERIOD_PS) - N_AS - N_WH);
    localparam int N_RD  = max3(clocks_for(T_ADDR_ACCESS_PS, CLK_PERIOD_PS),
                                clocks_for(T_OE_ACCESS_PS, CLK_PERIOD_PS),
                                clocks_for(T_RD_CYCLE_PS, CLK_PERIOD_PS) - N_AS);
    localparam int N_REL = clocks_for(T_OE_RELEASE_PS, CLK_PERIOD_PS);

    phase_e            phase_q;
    logic              write_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic              load;
    logic [CNT_W-1:0]  len;
    logic              last;
    logic              accept;
    logic              null_req;
    logic              active;

    assign accept   = req_valid && (phase_q == PH_IDLE);
    assign null_req = (req_be == '0);

    // Choose which phase length to load when a phase begins.
    always_comb begin
        load = 1'b0;
        len  = CNT_W'(1);
        unique case (phase_q)
            PH_IDLE:   begin load = accept && !null_req; len = CNT_W'(N_AS); end
            PH_ADDR:   begin load = last; len = write_q ? CNT_W'(N_WP) : CNT_W'(N_RD); end
            PH_WPULSE: begin load = last; len = CNT_W'(N_WH); end
            PH_READ:   begin load = last; len = CNT_W'(N_REL); end
            default:   begin load = 1'b0; len = CNT_W'(1); end
        endcase
    end

    sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .len   (len),
        .last  (last)
    );

    // Phase sequencing and request latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            write_q  <= 1'b0;
            be_q     <= '0;
            wdata_q  <= '0;
            mem_addr <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (accept && !null_req) begin
                    phase_q  <= PH_ADDR;
                    write_q  <= req_write;
                    be_q     <= req_be;
                    wdata_q  <= req_wdata;
                    mem_addr <= req_addr;
                end
                PH_ADDR:   if (last) phase_q <= write_q ? PH_WPULSE : PH_READ;
                PH_WPULSE: if (last) phase_q <= PH_WHOLD;
                PH_WHOLD:  if (last) phase_q <= PH_IDLE;
                PH_READ:   if (last) phase_q <= PH_TURN;
                PH_TURN:   if (last) phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // One-cycle response strobe after a real or empty read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_valid <= 1'b0;
        else
            rsp_valid <= ((phase_q == PH_READ) && last)
                       || (accept && null_req && !req_write);
    end

    sram_lane_capture #(.DATA_W(DATA_W)) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture ((phase_q == PH_READ) && last),
        .clear   (accept && null_req && !req_write),
        .lane_en (be_q),
        .dq_in   (mem_dq_in),
        .rdata   (rsp_rdata)
    );

    // Pin decode from the registered phase.
    assign active     = (phase_q == PH_WPULSE) || (phase_q == PH_READ);
    assign req_ready  = (phase_q == PH_IDLE);
    assign mem_ce_n   = !active;
    assign mem_we_n   = (phase_q != PH_WPULSE);
    assign mem_oe_n   = (phase_q != PH_READ);
    assign mem_bsel_n = active ? ~be_q : {LANES{1'b1}};
    assign mem_dq_oe  = (phase_q == PH_WPULSE) || (phase_q == PH_WHOLD);
    assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
// Module: protocol checker for sram_async_ctrl, attached by bind.
// Assumes the bound instance's default 19/16-bit widths or matching overrides.
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 19,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_bsel_n,
    input logic              mem_dq_oe
);
    logic quiet;
    assign quiet = mem_ce_n && mem_we_n && mem_oe_n && (&mem_bsel_n);

    a_r2_addr_under_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != $past(mem_addr)) |-> (quiet && $past(quiet)));

    a_r6_no_oe_we_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    a_r5_drive_only_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    a_r8_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r10_ready_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (quiet && !mem_dq_oe));

    a_r4_select_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&mem_bsel_n)) |-> !mem_ce_n);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_bsel_n (mem_bsel_n),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
// Bench: sweeps byte enables and addresses with slow timing so that phases
// span several clocks; a small memory model answers on the bus.
module test_sram_async_ctrl;
    // 50 MHz clock; the timing below gives these counts (ceil, min 1):
    // setup 30000/20000 -> 2, hold 0 -> 1, pulse 50000 -> 3, data setup -> 1,
    // write cycle 130000 -> 7 => pulse max(3,1,7-2-1=4) = 4;
    // access 50000 -> 3, oe access -> 1, read cycle 70000 -> 4-2=2 => 3;
    // release 25000 -> 2.
    localparam int EXP_AS = 2, EXP_WP = 4, EXP_WH = 1, EXP_RD = 3, EXP_REL = 2;
    localparam logic [18:0] POISON_ADDR = 19'h00055;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_bsel_n;
    logic [15:0] mem_dq_out, mem_dq_in;

    int checks = 0;
    int fails  = 0;
    int mon_bad = 0;
    logic [15:0] model [256];
    logic [15:0] shadow [256];

    always #10ns clk = ~clk;

    sram_async_ctrl #(
        .T_ADDR_SETUP_PS(30000), .T_WE_PULSE_PS(50000), .T_DATA_SETUP_PS(6000),
        .T_WR_HOLD_PS(0), .T_WR_CYCLE_PS(130000), .T_ADDR_ACCESS_PS(50000),
        .T_OE_ACCESS_PS(4500), .T_RD_CYCLE_PS(70000), .T_OE_RELEASE_PS(25000)
    ) i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_bsel_n(mem_bsel_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: drives while selected for reading, stores enabled lanes.
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? model[mem_addr[7:0]] : 16'hBEEF;
    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_bsel_n[0]) model[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_bsel_n[1]) model[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    // Per-cycle protocol monitor (R2, R5, R6).
    logic [18:0] prev_addr;
    logic        prev_quiet;
    logic        mon_on = 1'b0;
    always @(negedge clk) begin
        logic quiet;
        quiet = mem_ce_n && mem_we_n && mem_oe_n && (&mem_bsel_n);
        if (mon_on) begin
            if (mem_addr != prev_addr && !(quiet && prev_quiet)) begin
                mon_bad++; $display("FAIL R2 addr change under strobe: %h -> %h", prev_addr, mem_addr);
            end
            if (mem_dq_oe && !mem_oe_n) begin
                mon_bad++; $display("FAIL R5 bus driven with oe low: oe_n=%b expected 1", mem_oe_n);
            end
            if (!mem_oe_n && !mem_we_n) begin
                mon_bad++; $display("FAIL R6 oe and we low together: oe_n=%b we_n=%b", mem_oe_n, mem_we_n);
            end
        end
        prev_addr  = mem_addr;
        prev_quiet = quiet;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue one request and measure its phases at the pins.
    task automatic do_req(input logic [18:0] a, input logic [15:0] d,
                          input logic wr, input logic [1:0] be,
                          output logic [15:0] rd);
        int pre, act, post;
        int stage;
        int rsp_seen, rsp_at_post;
        bit pin_bad, bus_bad;
        logic [18:0] addr_before;
        pre = 0; act = 0; post = 0; stage = 0;
        rsp_seen = 0; rsp_at_post = -1; pin_bad = 0; bus_bad = 0;
        rd = 16'h0;
        @(negedge clk);
        addr_before = mem_addr;
        req_valid = 1'b1; req_addr = a; req_wdata = d; req_write = wr; req_be = be;
        @(negedge clk);
        // Held poison request while busy (R10).
        req_addr = POISON_ADDR; req_wdata = 16'hDEAD; req_write = 1'b1; req_be = 2'b11;
        while (!req_ready) begin
            logic quiet;
            quiet = mem_ce_n && mem_we_n && mem_oe_n && (&mem_bsel_n);
            if (stage == 0 && !quiet) stage = 1;
            if (stage == 1 && quiet) stage = 2;
            if (stage == 0) pre++;
            else if (stage == 1) begin
                act++;
                if (mem_ce_n || mem_bsel_n != ~be) pin_bad = 1;
                if (wr && (mem_we_n || !mem_oe_n || !mem_dq_oe || mem_dq_out != d)) pin_bad = 1;
                if (!wr && (!mem_we_n || mem_oe_n || mem_dq_oe)) pin_bad = 1;
            end else begin
                post++;
                if (wr && (!mem_dq_oe || mem_dq_out != d)) bus_bad = 1;
                if (!wr && mem_dq_oe) bus_bad = 1;
            end
            if (stage == 0 && mem_dq_oe) bus_bad = 1;
            if (rsp_valid) begin rsp_seen++; rsp_at_post = post; rd = rsp_rdata; end
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (rsp_valid) begin rsp_seen++; rd = rsp_rdata; end
        if (be == 2'b00) begin
            check(pre == 0 && act == 0 && post == 0, "R11", "strobe cycles on empty request", pre + act + post, 0);
            check(mem_addr == addr_before, "R11", "address moved on empty request", mem_addr, addr_before);
            if (!wr) check(rsp_seen == 1 && rd == 16'h0, "R11", "empty read response", rd, 0);
        end else if (wr) begin
            check(pre == EXP_AS, "R3", "write setup cycles", pre, EXP_AS);
            check(act == EXP_WP, "R3", "write pulse cycles", act, EXP_WP);
            check(post == EXP_WH, "R3", "write hold cycles", post, EXP_WH);
            check(!pin_bad, "R4", "write pin pattern", mem_bsel_n, ~be);
            check(!bus_bad, "R5", "write bus drive", mem_dq_out, d);
        end else begin
            check(pre == EXP_AS, "R7", "read setup cycles", pre, EXP_AS);
            check(act == EXP_RD, "R7", "read phase cycles", act, EXP_RD);
            check(post == EXP_REL, "R9", "release cycles", post, EXP_REL);
            check(!pin_bad && !bus_bad, "R4", "read pin pattern", mem_bsel_n, ~be);
            check(rsp_seen == 1 && rsp_at_post == 1, "R8", "response pulse position", rsp_at_post, 1);
        end
    endtask

    function automatic logic [15:0] pattern(input logic [18:0] a, input int k);
        return 16'(a[15:0] * 16'd97 + 16'(k) * 16'h1357 + 16'h0A0F);
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    initial begin
        logic [18:0] addrs [4];
        logic [15:0] got;
        addrs[0] = 19'h00000; addrs[1] = 19'h00001; addrs[2] = 19'h7FFFF; addrs[3] = 19'h2A5A5;
        for (int i = 0; i < 256; i++) begin
            model[i]  = 16'(i) * 16'h0101 ^ 16'h5A5A;
            shadow[i] = 16'(i) * 16'h0101 ^ 16'h5A5A;
        end
        repeat (3) @(negedge clk);
        // R1 reset state during and just after reset.
        check(mem_ce_n && mem_we_n && mem_oe_n && (&mem_bsel_n) && !mem_dq_oe,
              "R1", "strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_bsel_n}, 5'h1F);
        check(req_ready && !rsp_valid, "R1", "handshake in reset", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && (&mem_bsel_n) && !mem_dq_oe && req_ready && !rsp_valid,
              "R1", "state after reset", {mem_ce_n, mem_oe_n, req_ready, rsp_valid}, 4'b1110);
        mon_on = 1'b1;
        // Sweep addresses x byte enables: write then full read (R3, R4, R12).
        for (int ai = 0; ai < 4; ai++) begin
            for (int b = 0; b < 4; b++) begin
                logic [15:0] d;
                d = pattern(addrs[ai], b);
                do_req(addrs[ai], d, 1'b1, 2'(b), got);
                shadow[addrs[ai][7:0]] = (shadow[addrs[ai][7:0]] & ~lane_mask(2'(b))) | (d & lane_mask(2'(b)));
                do_req(addrs[ai], 16'h0, 1'b0, 2'b11, got);
                check(got == shadow[addrs[ai][7:0]], "R12", "readback after lane write", got, shadow[addrs[ai][7:0]]);
            end
        end
        // Masked reads over every pattern (R8).
        for (int ai = 0; ai < 4; ai++) begin
            for (int b = 0; b < 4; b++) begin
                logic [15:0] e;
                do_req(addrs[ai], 16'h0, 1'b0, 2'(b), got);
                e = (b == 0) ? 16'h0 : (shadow[addrs[ai][7:0]] & lane_mask(2'(b)));
                check(got == e, "R8", "masked read data", got, e);
            end
        end
        // Held request during busy phases must not have landed (R10).
        do_req(POISON_ADDR, 16'h0, 1'b0, 2'b11, got);
        check(got == shadow[POISON_ADDR[7:0]], "R10", "busy-time request ignored", got, shadow[POISON_ADDR[7:0]]);
        check(mon_bad == 0, "R2", "per-cycle protocol monitor violations", mon_bad, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog expired: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule